// File: doc/BRIEF.md
# Instruction Register Dispatch Unit

This block sits beside a microsequencer that runs a 16-bit instruction set in microcode. It holds the current instruction word and turns it into the small values the microcode needs. When the microcode fetches an instruction it pulses a load strobe with the word on the bus. The register captures the word, and in the same cycle a 4-bit first-level dispatch comes out to be ORed into the next microaddress. A later request gives a second-level dispatch. For arithmetic words this comes from the shift field. For every other word it comes from an external table, which this block addresses.

The block also serves the microcode's bus reads. The bus is wired-AND. When the displacement source or the node-identifier source is selected, that value is ANDed into the incoming bus word. The unit rewrites the low bits of a register-file select to point at the source or destination accumulator. It keeps a skip latch that a fetch clears. It decodes a start-I/O bus word into a one-cycle soft-boot pulse or a one-cycle network-start pulse.

Bit numbers below count from the most significant bit. Bit 0 is port bit 15 and bit 15 is port bit 0.

Top module: `ir_dispatch_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `ir_q`, `skip_q`, `boot_pulse` and `net_pulse` to 0.
- R2: At an edge with `ld_ir` high, `ir_q` takes `bus_in` and `skip_q` becomes 0. This clear wins over `skip_set` in the same cycle.
- R3: At an edge with `skip_set` high and `ld_ir` low, `skip_q` becomes 1. It then holds until a load or a reset.
- R4: While `ld_ir` is high, `ld_dispatch` combinationally equals {bus bit 0, bus bits 5-7}, with bus bit 0 as its MSB. While `ld_ir` is low it is 0.
- R5: While `rd_disp` is high, `bus_out` is `bus_in` ANDed with a displacement word. The word's low byte is instruction bits 8-15. If the index field (instruction bits 6-7) is 0, the high byte is zero. Otherwise the low byte is sign-extended from its top bit.
- R6: While `rd_node` is high, `bus_in` is ANDed with {8'hFF, `node_id`}. Both read requests may be active together. With neither active, `bus_out` equals `bus_in`.
- R7: While `disp2_req` is high and instruction bit 0 is 1 (arithmetic), `disp2_out` is the shift field (instruction bits 8-9) XOR 3, zero-extended. `tbl_entry` is ignored.
- R8: While `disp2_req` is high and instruction bit 0 is 0, `disp2_out` equals `tbl_entry`. `tbl_addr` is always instruction bits 1-7. With `disp2_req` low, `disp2_out` is 0.
- R9: While `sel_dst` is high, `rsel_out` is `rsel_in` with its two low bits replaced by instruction bits 3-4 XOR 3. This takes priority over `sel_src`.
- R10: While `sel_src` is high and `sel_dst` is low, the two low bits become instruction bits 1-2 XOR 3. The upper select bits always pass through unchanged, and with neither select high `rsel_out` equals `rsel_in`.
- R11: An edge with `sio_stb` high makes exactly one of the pulses high for the following cycle. If bus bit 0 is 1, `boot_pulse` is raised; otherwise `net_pulse` is raised. Each pulse ends after one cycle unless the strobe repeats.
- R12: The field outputs decode `ir_q` for non-arithmetic words:
  - `f_arith` is bit 0.
  - `f_mem` is bits 1-2.
  - `f_jump` is bits 3-4.
  - `f_ind` is bit 5.
  - `f_idx` is bits 6-7: 0 page zero, 1 PC-relative, 2 AC2-relative, 3 AC3-relative.
  - `f_disp` is bits 8-15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_in | input | 16 | Current bus word |
| ld_ir | input | 1 | Load instruction register strobe |
| skip_set | input | 1 | Set the skip latch |
| rd_disp | input | 1 | Drive displacement onto the bus |
| rd_node | input | 1 | Drive node-identifier word onto the bus |
| node_id | input | 8 | Node identifier |
| disp2_req | input | 1 | Second-level dispatch request |
| tbl_entry | input | 4 | External table entry for non-arithmetic dispatch |
| sel_src | input | 1 | Select source accumulator |
| sel_dst | input | 1 | Select destination accumulator |
| rsel_in | input | 5 | Incoming register select |
| sio_stb | input | 1 | Start-I/O strobe |
| ir_q | output | 16 | Instruction register |
| skip_q | output | 1 | Skip latch |
| ld_dispatch | output | 4 | First-level dispatch value |
| disp2_out | output | 4 | Second-level dispatch value |
| tbl_addr | output | 7 | External table index |
| bus_out | output | 16 | Bus word after wired-AND of selected sources |
| rsel_out | output | 5 | Modified register select |
| boot_pulse | output | 1 | Soft-boot pulse |
| net_pulse | output | 1 | Network-start pulse |
| f_arith | output | 1 | Arithmetic flag |
| f_mem | output | 2 | Memory function field |
| f_jump | output | 2 | Jump function field |
| f_ind | output | 1 | Indirect flag |
| f_idx | output | 2 | Index mode field |
| f_disp | output | 8 | Displacement field |

## Verification
The assertions hold on every cycle for the following behaviours:
- The register captures the bus on a load and the skip latch is cleared.
- The skip latch is set when requested.
- The dispatch outputs are zero when no strobe is present.
- The bus output never carries a bit that the incoming bus lacks.
- The upper select bits always pass through.
- Each start-I/O pulse traces back to a strobe with the matching bus bit 0.

Only the bench scenarios can show the exact values:
- the bit gathering of the first-level dispatch;
- sign versus zero extension of the displacement for each index mode;
- the inverted accumulator numbers;
- the table pass-through;
- the one-cycle width of each start-I/O pulse.

// File: rtl/irdu_pkg.sv
package irdu_pkg;
  localparam int WORD_W  = 16;
  localparam int DISP_W  = 8;
  localparam int LDSP_W  = 4;
  localparam int TADDR_W = 7;

  typedef enum logic [1:0] {
    IDX_PAGE0  = 2'd0,
    IDX_PCREL  = 2'd1,
    IDX_AC2REL = 2'd2,
    IDX_AC3REL = 2'd3
  } idx_mode_e;

  // Packed view of a non-arithmetic word, MSB first
  typedef struct packed {
    logic              arith;
    logic [1:0]        mem_fn;
    logic [1:0]        jmp_fn;
    logic              ind;
    idx_mode_e         idx;
    logic [DISP_W-1:0] disp;
  } ir_fields_t;

  // Displacement widened to a word: zero for page zero, sign otherwise
  function automatic logic [WORD_W-1:0] widen_disp(input idx_mode_e idx,
                                                    input logic [DISP_W-1:0] d);
    logic fill;
    fill = (idx != IDX_PAGE0) && d[DISP_W-1];
    return {{(WORD_W-DISP_W){fill}}, d};
  endfunction

  // Accumulator number to register-select bits (inverted)
  function automatic logic [1:0] ac_to_sel(input logic [1:0] ac);
    return ac ^ 2'b11;
  endfunction
endpackage

// File: rtl/irdu_ir_reg.sv
module irdu_ir_reg
  import irdu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic              skip_set,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q,
  output logic              skip_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= '0;
      skip_q <= 1'b0;
    end else if (ld) begin
      q      <= d;
      skip_q <= 1'b0;
    end else if (skip_set) begin
      skip_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irdu_bus_src.sv
module irdu_bus_src
  import irdu_pkg::*;
#(
  parameter int NODE_W = 8
) (
  input  logic              rd_disp,
  input  logic              rd_node,
  input  idx_mode_e         idx,
  input  logic [DISP_W-1:0] disp,
  input  logic [NODE_W-1:0] node_id,
  input  logic [WORD_W-1:0] bus_in,
  output logic [WORD_W-1:0] bus_out
);
  localparam int HI_W = WORD_W - NODE_W;

  logic [WORD_W-1:0] disp_word;
  logic [WORD_W-1:0] node_word;
  logic [WORD_W-1:0] disp_mask;
  logic [WORD_W-1:0] node_mask;

  always_comb begin
    disp_word = widen_disp(idx, disp);
    node_word = {{HI_W{1'b1}}, node_id};
    disp_mask = rd_disp ? disp_word : '1;
    node_mask = rd_node ? node_word : '1;
    bus_out   = bus_in & disp_mask & node_mask;
  end
endmodule

// File: rtl/irdu_dispatch.sv
module irdu_dispatch
  import irdu_pkg::*;
#(
  parameter int TBL_W = 4
) (
  input  logic              ld_ir,
  input  logic [LDSP_W-1:0] ld_bits,
  input  logic              disp2_req,
  input  logic              arith,
  input  logic [1:0]        shift_fld,
  input  logic [TBL_W-1:0]  tbl_entry,
  output logic [LDSP_W-1:0] ld_dispatch,
  output logic [TBL_W-1:0]  disp2_out
);
  logic [TBL_W-1:0] arith_val;

  generate
    if (TBL_W > 2) begin : g_wide
      assign arith_val = {{(TBL_W-2){1'b0}}, shift_fld ^ 2'b11};
    end else begin : g_narrow
      assign arith_val = shift_fld ^ 2'b11;
    end
  endgenerate

  always_comb begin
    ld_dispatch = ld_ir ? ld_bits : '0;
    if (!disp2_req)  disp2_out = '0;
    else if (arith)  disp2_out = arith_val;
    else             disp2_out = tbl_entry;
  end
endmodule

// File: rtl/irdu_regsel.sv
module irdu_regsel
  import irdu_pkg::*;
#(
  parameter int RSEL_W = 5
) (
  input  logic              sel_src,
  input  logic              sel_dst,
  input  logic [1:0]        src_ac,
  input  logic [1:0]        dst_ac,
  input  logic [RSEL_W-1:0] rsel_in,
  output logic [RSEL_W-1:0] rsel_out
);
  logic [1:0] low_bits;

  always_comb begin
    if (sel_dst)      low_bits = ac_to_sel(dst_ac);
    else if (sel_src) low_bits = ac_to_sel(src_ac);
    else              low_bits = rsel_in[1:0];
  end

  generate
    if (RSEL_W > 2) begin : g_upper
      assign rsel_out = {rsel_in[RSEL_W-1:2], low_bits};
    end else begin : g_only
      assign rsel_out = low_bits;
    end
  endgenerate
endmodule

// File: rtl/irdu_sio.sv
module irdu_sio (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic boot_bit,
  output logic boot_pulse,
  output logic net_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      boot_pulse <= 1'b0;
      net_pulse  <= 1'b0;
    end else begin
      boot_pulse <= stb &  boot_bit;
      net_pulse  <= stb & ~boot_bit;
    end
  end
endmodule

// File: rtl/ir_dispatch_unit.sv
module ir_dispatch_unit
  import irdu_pkg::*;
#(
  parameter int NODE_W = 8,
  parameter int TBL_W  = 4,
  parameter int RSEL_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [WORD_W-1:0]   bus_in,
  input  logic                ld_ir,
  input  logic                skip_set,
  input  logic                rd_disp,
  input  logic                rd_node,
  input  logic [NODE_W-1:0]   node_id,
  input  logic                disp2_req,
  input  logic [TBL_W-1:0]    tbl_entry,
  input  logic                sel_src,
  input  logic                sel_dst,
  input  logic [RSEL_W-1:0]   rsel_in,
  input  logic                sio_stb,
  output logic [WORD_W-1:0]   ir_q,
  output logic                skip_q,
  output logic [LDSP_W-1:0]   ld_dispatch,
  output logic [TBL_W-1:0]    disp2_out,
  output logic [TADDR_W-1:0]  tbl_addr,
  output logic [WORD_W-1:0]   bus_out,
  output logic [RSEL_W-1:0]   rsel_out,
  output logic                boot_pulse,
  output logic                net_pulse,
  output logic                f_arith,
  output logic [1:0]          f_mem,
  output logic [1:0]          f_jump,
  output logic                f_ind,
  output logic [1:0]          f_idx,
  output logic [DISP_W-1:0]   f_disp
);
  ir_fields_t        fld;
  logic [LDSP_W-1:0] ld_bits_w;
  logic              sio_boot_bit_w;
  logic [1:0]        src_ac_w;
  logic [1:0]        dst_ac_w;
  logic [1:0]        shift_w;

  irdu_ir_reg u_ir (
    .clk(clk), .rst(rst), .ld(ld_ir), .skip_set(skip_set),
    .d(bus_in), .q(ir_q), .skip_q(skip_q)
  );

  assign fld            = ir_fields_t'(ir_q);
  assign ld_bits_w      = {bus_in[WORD_W-1], bus_in[10:8]};
  assign sio_boot_bit_w = bus_in[WORD_W-1];
  assign src_ac_w       = fld.mem_fn;
  assign dst_ac_w       = fld.jmp_fn;
  assign shift_w        = fld.disp[DISP_W-1 -: 2];
  assign tbl_addr       = ir_q[WORD_W-2 -: TADDR_W];

  irdu_bus_src #(.NODE_W(NODE_W)) u_bus (
    .rd_disp(rd_disp), .rd_node(rd_node), .idx(fld.idx), .disp(fld.disp),
    .node_id(node_id), .bus_in(bus_in), .bus_out(bus_out)
  );

  irdu_dispatch #(.TBL_W(TBL_W)) u_disp (
    .ld_ir(ld_ir), .ld_bits(ld_bits_w), .disp2_req(disp2_req),
    .arith(fld.arith), .shift_fld(shift_w), .tbl_entry(tbl_entry),
    .ld_dispatch(ld_dispatch), .disp2_out(disp2_out)
  );

  irdu_regsel #(.RSEL_W(RSEL_W)) u_rsel (
    .sel_src(sel_src), .sel_dst(sel_dst), .src_ac(src_ac_w), .dst_ac(dst_ac_w),
    .rsel_in(rsel_in), .rsel_out(rsel_out)
  );

  irdu_sio u_sio (
    .clk(clk), .rst(rst), .stb(sio_stb), .boot_bit(sio_boot_bit_w),
    .boot_pulse(boot_pulse), .net_pulse(net_pulse)
  );

  assign f_arith = fld.arith;
  assign f_mem   = fld.mem_fn;
  assign f_jump  = fld.jmp_fn;
  assign f_ind   = fld.ind;
  assign f_idx   = fld.idx;
  assign f_disp  = fld.disp;
endmodule

// File: rtl/irdu_checker.sv
module irdu_checker #(
  parameter int TBL_W  = 4,
  parameter int RSEL_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       bus_in,
  input logic              ld_ir,
  input logic              skip_set,
  input logic              disp2_req,
  input logic              sel_src,
  input logic              sel_dst,
  input logic [RSEL_W-1:0] rsel_in,
  input logic              sio_stb,
  input logic [15:0]       ir_q,
  input logic              skip_q,
  input logic [3:0]        ld_dispatch,
  input logic [TBL_W-1:0]  disp2_out,
  input logic [15:0]       bus_out,
  input logic [RSEL_W-1:0] rsel_out,
  input logic              boot_pulse,
  input logic              net_pulse
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ir_q == 16'h0) && !skip_q && !boot_pulse && !net_pulse);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ld_ir |=> (ir_q == $past(bus_in)) && !skip_q);

  // R3
  skip_set_chk: assert property (@(posedge clk) disable iff (rst)
    (skip_set && !ld_ir) |=> skip_q);

  // R4
  ld_dispatch_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_ir |-> (ld_dispatch == 4'h0));

  // R5
  bus_wired_and_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_out & ~bus_in) == 16'h0);

  // R8
  disp2_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !disp2_req |-> (disp2_out == '0));

  // R10
  rsel_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_src && !sel_dst) |-> (rsel_out == rsel_in));

  // R10
  rsel_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (rsel_out >> 2) == (rsel_in >> 2));

  // R11
  boot_origin_chk: assert property (@(posedge clk) disable iff (rst)
    boot_pulse |-> ($past(sio_stb) && $past(bus_in[15])));

  // R11
  net_origin_chk: assert property (@(posedge clk) disable iff (rst)
    net_pulse |-> ($past(sio_stb) && !$past(bus_in[15])));

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({boot_pulse, net_pulse}));
endmodule

bind ir_dispatch_unit irdu_checker #(.TBL_W(TBL_W), .RSEL_W(RSEL_W)) u_chk (
  .clk(clk), .rst(rst), .bus_in(bus_in), .ld_ir(ld_ir), .skip_set(skip_set),
  .disp2_req(disp2_req), .sel_src(sel_src), .sel_dst(sel_dst),
  .rsel_in(rsel_in), .sio_stb(sio_stb), .ir_q(ir_q), .skip_q(skip_q),
  .ld_dispatch(ld_dispatch), .disp2_out(disp2_out), .bus_out(bus_out),
  .rsel_out(rsel_out), .boot_pulse(boot_pulse), .net_pulse(net_pulse)
);

// File: tb/tb_ir_dispatch_unit.sv
module tb_ir_dispatch_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_in = '0;
  logic        ld_ir = 0, skip_set = 0, rd_disp = 0, rd_node = 0;
  logic [7:0]  node_id = '0;
  logic        disp2_req = 0;
  logic [3:0]  tbl_entry = '0;
  logic        sel_src = 0, sel_dst = 0;
  logic [4:0]  rsel_in = '0;
  logic        sio_stb = 0;
  logic [15:0] ir_q, bus_out;
  logic        skip_q, boot_pulse, net_pulse, f_arith, f_ind;
  logic [3:0]  ld_dispatch, disp2_out;
  logic [6:0]  tbl_addr;
  logic [4:0]  rsel_out;
  logic [1:0]  f_mem, f_jump, f_idx;
  logic [7:0]  f_disp;

  int n_chk = 0, n_bad = 0;

  ir_dispatch_unit dut (
    .clk(clk), .rst(rst), .bus_in(bus_in), .ld_ir(ld_ir), .skip_set(skip_set),
    .rd_disp(rd_disp), .rd_node(rd_node), .node_id(node_id),
    .disp2_req(disp2_req), .tbl_entry(tbl_entry), .sel_src(sel_src),
    .sel_dst(sel_dst), .rsel_in(rsel_in), .sio_stb(sio_stb), .ir_q(ir_q),
    .skip_q(skip_q), .ld_dispatch(ld_dispatch), .disp2_out(disp2_out),
    .tbl_addr(tbl_addr), .bus_out(bus_out), .rsel_out(rsel_out),
    .boot_pulse(boot_pulse), .net_pulse(net_pulse), .f_arith(f_arith),
    .f_mem(f_mem), .f_jump(f_jump), .f_ind(f_ind), .f_idx(f_idx), .f_disp(f_disp)
  );

  always #5 clk = ~clk;

  // MSB-first field extraction: bit 0 is the word's top bit
  function automatic int unsigned fld(input logic [15:0] w, input int a, input int b);
    int unsigned v = 0;
    for (int k = a; k <= b; k++) v = (v << 1) | int'(w[15-k]);
    return v;
  endfunction

  function automatic logic [15:0] exp_disp_word(input logic [15:0] w);
    int unsigned d = fld(w, 8, 15);
    if (fld(w, 6, 7) != 0 && d >= 128) return 16'(d + 16'hFF00);
    return 16'(d);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic load_ir(input logic [15:0] w);
    bus_in = w; ld_ir = 1; step(); ld_ir = 0; bus_in = '0;
  endtask

  task automatic t_reset();
    chk("R1 ir", ir_q, 0); chk("R1 skip", skip_q, 0);
    chk("R1 boot", boot_pulse, 0); chk("R1 net", net_pulse, 0);
    load_ir(16'h1234); skip_set = 1; step(); skip_set = 0;
    rst = 1; step(); rst = 0;
    chk("R1 ir after mid reset", ir_q, 0); chk("R1 skip after mid reset", skip_q, 0);
  endtask

  task automatic t_load();
    logic [15:0] pats [4] = '{16'hA5C3, 16'h0700, 16'h7FFF, 16'h8000};
    foreach (pats[i]) begin
      bus_in = pats[i]; ld_ir = 1; #1;
      chk("R4 dispatch", ld_dispatch, (fld(pats[i], 0, 0) << 3) | fld(pats[i], 5, 7));
      step(); ld_ir = 0; bus_in = '0; #1;
      chk("R2 capture", ir_q, pats[i]);
      chk("R4 idle", ld_dispatch, 0);
    end
  endtask

  task automatic t_skip();
    skip_set = 1; step(); skip_set = 0;
    chk("R3 set", skip_q, 1);
    step(); chk("R3 hold", skip_q, 1);
    load_ir(16'h0001); chk("R2 clear", skip_q, 0);
    skip_set = 1; load_ir(16'h0002); skip_set = 0;
    chk("R2 clear wins over set", skip_q, 0);
  endtask

  task automatic t_disp();
    logic [15:0] irs [4] = '{16'h0080, 16'h0180, 16'h027F, 16'h03C1};
    foreach (irs[i]) begin
      load_ir(irs[i]);
      bus_in = 16'hFFFF; rd_disp = 1; #1;
      chk("R5 disp full bus", bus_out, exp_disp_word(irs[i]));
      bus_in = 16'h0FF0; #1;
      chk("R5 disp wired-and", bus_out, exp_disp_word(irs[i]) & 16'h0FF0);
      rd_disp = 0; bus_in = '0;
    end
  endtask

  task automatic t_node();
    node_id = 8'h3C; rd_node = 1; bus_in = 16'hFFFF; #1;
    chk("R6 node", bus_out, 16'hFF3C);
    bus_in = 16'h0F0F; #1;
    chk("R6 node wired-and", bus_out, 16'h0F0C);
    load_ir(16'h0181); rd_node = 1; rd_disp = 1; bus_in = 16'hFFFF; #1;
    chk("R6 both sources", bus_out, 16'hFF3C & exp_disp_word(16'h0181));
    rd_node = 0; rd_disp = 0; bus_in = 16'h5AA5; #1;
    chk("R6 no source", bus_out, 16'h5AA5);
    bus_in = '0;
  endtask

  task automatic t_disp2();
    for (int s = 0; s < 4; s++) begin
      logic [15:0] w = 16'h8000 | 16'(s << 6);
      load_ir(w); tbl_entry = 4'hB; disp2_req = 1; #1;
      chk("R7 arith shift", disp2_out, 4'(fld(w, 8, 9) ^ 3));
      disp2_req = 0;
    end
    load_ir(16'h5A00); tbl_entry = 4'h9; disp2_req = 1; #1;
    chk("R8 table entry", disp2_out, 4'h9);
    chk("R8 table addr", tbl_addr, fld(16'h5A00, 1, 7));
    disp2_req = 0; #1;
    chk("R8 idle", disp2_out, 0);
  endtask

  task automatic t_rsel();
    logic [15:0] w = 16'h9800;
    load_ir(w); rsel_in = 5'b10100;
    sel_dst = 1; #1;
    chk("R9 dst", rsel_out, {3'b101, 2'(fld(w, 3, 4) ^ 3)});
    sel_src = 1; #1;
    chk("R9 dst priority", rsel_out, {3'b101, 2'(fld(w, 3, 4) ^ 3)});
    sel_dst = 0; #1;
    chk("R10 src", rsel_out, {3'b101, 2'(fld(w, 1, 2) ^ 3)});
    sel_src = 0; #1;
    chk("R10 none", rsel_out, 5'b10100);
  endtask

  task automatic t_sio();
    bus_in = 16'h8000; sio_stb = 1; step(); sio_stb = 0; bus_in = '0;
    chk("R11 boot", boot_pulse, 1); chk("R11 no net", net_pulse, 0);
    step(); chk("R11 boot width", boot_pulse, 0);
    bus_in = 16'h0003; sio_stb = 1; step(); sio_stb = 0; bus_in = '0;
    chk("R11 net", net_pulse, 1); chk("R11 no boot", boot_pulse, 0);
    step(); chk("R11 net width", net_pulse, 0);
  endtask

  task automatic t_fields();
    logic [15:0] w = 16'h2D47;
    load_ir(w);
    chk("R12 arith", f_arith, fld(w, 0, 0)); chk("R12 mem", f_mem, fld(w, 1, 2));
    chk("R12 jump", f_jump, fld(w, 3, 4));  chk("R12 ind", f_ind, fld(w, 5, 5));
    chk("R12 idx", f_idx, fld(w, 6, 7));    chk("R12 disp", f_disp, fld(w, 8, 15));
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk); #1; rst = 0;
        t_reset(); t_load(); t_skip(); t_disp(); t_node();
        t_disp2(); t_rsel(); t_sio(); t_fields();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule